// File: doc/BRIEF.md
# Multiplexed Pixel Bus Capture Unit

This block sits behind a narrow pixel port fed by a graphics source. The source sends each pixel as two byte transfers, phase a followed by phase b, at twice the pixel rate. The block rebuilds whole pixels from that stream. A two-bit edge select chooses when the bus is sampled: the rising edge of the capture clock only, the falling edge only, or both edges. In both-edge mode the rising-edge byte is phase a and the falling-edge byte is phase b, and the pair is merged in the rising-edge domain. A two-bit format select picks the packing: RGB 5-6-5, RGB 5-5-5, or 4:2:2 luma/chroma with the byte order Cb, Y0, Cr, Y1.

A horizontal sync input restarts the phase tracking on every line. After sync falls, a programmable number of capture-clock cycles is discarded. The first transfer after that is always phase a. The output is a one-cycle strobe. With it come either the R, G and B fields or a luma sample together with the chroma pair that belongs to it.

Two state machines do the work. The line tracker has the states SYNC, SKIP and LIVE:
- SYNC goes to SKIP when sync falls and the skip count is nonzero.
- SYNC goes straight to LIVE when sync falls and the count is zero.
- SKIP goes to LIVE once the counted cycles have passed.
- Any state goes to SYNC while sync is high.

The assembler has the states PH_A, PH_B, PH_CR and PH_Y1:
- In RGB, PH_A and PH_B alternate, or PH_A repeats when both edges are used.
- In luma/chroma, the order is PH_A (Cb), PH_B (Y0), PH_CR (Cr), PH_Y1 (Y1). With both edges it shortens to PH_A, PH_CR.
- A line restart forces PH_A.

Top module: `pcap_capture_top`

## Requirements
- R1: After reset the pixel strobe is low and stays low until valid transfers arrive.
- R2: Format code 00 (RGB 5-6-5): phase a bits 7..5 are G[2:0] and bits 4..0 are B[4:0]; phase b bits 7..3 are R[4:0] and bits 2..0 are G[5:3].
- R3: Format code 01 (RGB 5-5-5): phase a bits 7..5 are G[2:0] and bits 4..0 are B[4:0]; phase b bits 6..2 are R[4:0] and bits 1..0 are G[4:3]; phase b bit 7 has no effect, and the green MSB output is 0.
- R4: Format code 10 (luma/chroma): bytes arrive as Cb, Y0, Cr, Y1. One strobe is issued per luma sample, Y0 first and then Y1, and both carry the same Cb and Cr.
- R5: In both RGB formats exactly one strobe is issued per completed phase-a/phase-b pair. With single-edge capture, two RGB strobes are never adjacent.
- R6: Edge code 00 samples the bus on the rising edge only and 01 on the falling edge only. Codes 10 and 11 sample both edges, taking the rising byte as phase a and the falling byte as phase b of the same cycle.
- R7: While sync is high no byte is taken and no strobe follows a second sync cycle. A phase a left without its phase b when sync rises is dropped, and the next line starts at phase a.
- R8: After sync falls, the first skip-count capture cycles are discarded, and the cycle after them carries the first phase a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; the outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_sel_i | input | 2 | Sampling edge: 00 rising, 01 falling, 1x both |
| fmt_sel_i | input | 2 | Packing: 00 RGB 5-6-5, 01 RGB 5-5-5, 10 luma/chroma |
| skip_i | input | SKIP_W | Capture cycles discarded after sync falls |
| hs_i | input | 1 | Horizontal sync, high during the pulse |
| bus_i | input | 8 | Multiplexed pixel bus |
| pix_vld_o | output | 1 | One-cycle strobe for a finished pixel or luma sample |
| red_o | output | 5 | Red field |
| grn_o | output | 6 | Green field (bit 5 is 0 in 5-5-5) |
| blu_o | output | 5 | Blue field |
| luma_o | output | 8 | Luma sample |
| cb_o | output | 8 | Blue-difference chroma for this luma |
| cr_o | output | 8 | Red-difference chroma for this luma |

## Verification
The assertions assume that the edge select, the format select and the skip count change only while sync is high, and that sync is sampled on the rising edge alongside phase a. Under those assumptions the tracker counter stays within the skip count, and RGB strobes in single-edge mode stay apart. The stimulus follows the same rules: every configuration is applied during a sync pulse of several cycles before a line begins. Bytes change only a quarter period before the edge that is meant to sample them. The half cycle that the selected edge does not sample carries a filler byte, so sampling on the wrong edge would show up in the output.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int BUS_W  = 8;
    localparam int RED_W  = 5;
    localparam int GRN_W  = 6;
    localparam int BLU_W  = 5;
    localparam int RGB_W  = RED_W + GRN_W + BLU_W;

    localparam logic [1:0] FMT_565 = 2'b00;
    localparam logic [1:0] FMT_555 = 2'b01;
    localparam logic [1:0] FMT_YCC = 2'b10;

    localparam logic [1:0] EDGE_FALL = 2'b01;

    typedef enum logic [1:0] {
        TRK_SYNC = 2'd0,
        TRK_SKIP = 2'd1,
        TRK_LIVE = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        PH_A  = 2'd0,
        PH_B  = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } asm_state_e;

    // Returns {red, green, blue} from one phase-a and one phase-b byte.
    function automatic logic [RGB_W-1:0] unpack_rgb(
        input logic [1:0]       fmt,
        input logic [BUS_W-1:0] pa,
        input logic [BUS_W-1:0] pb
    );
        logic [RGB_W-1:0] res;
        if (fmt == FMT_555) begin
            res = {pb[6:2], 1'b0, pb[1:0], pa[7:5], pa[4:0]};
        end else begin
            res = {pb[7:3], pb[2:0], pa[7:5], pa[4:0]};
        end
        return res;
    endfunction

endpackage

// File: rtl/pcap_edge_front.sv
module pcap_edge_front
    import pcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       edge_sel_i,
    input  logic             hs_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             hs_q_o,
    output logic             dual_o,
    output logic [BUS_W-1:0] slot0_o,
    output logic [BUS_W-1:0] slot1_o
);

    logic [BUS_W-1:0] rise_q;
    logic [BUS_W-1:0] fall_q;
    logic             hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            hs_q   <= 1'b0;
        end else begin
            rise_q <= bus_i;
            hs_q   <= hs_i;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= bus_i;
        end
    end

    always_comb begin
        dual_o  = edge_sel_i[1];
        slot0_o = (edge_sel_i == EDGE_FALL) ? fall_q : rise_q;
        slot1_o = fall_q;
        hs_q_o  = hs_q;
    end

endmodule

// File: rtl/pcap_line_tracker.sv
module pcap_line_tracker
    import pcap_pkg::*;
#(
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_q_i,
    input  logic [SKIP_W-1:0] skip_i,
    output logic              live_o,
    output logic              restart_o
);

    trk_state_e        state_q;
    trk_state_e        state_d;
    logic [SKIP_W-1:0] cnt_q;
    logic [SKIP_W-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_SYNC;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        live_o    = 1'b0;
        restart_o = hs_q_i;
        unique case (state_q)
            TRK_SYNC: begin
                if (!hs_q_i) begin
                    if (skip_i == '0) begin
                        live_o  = 1'b1;
                        state_d = TRK_LIVE;
                    end else begin
                        cnt_d   = {{(SKIP_W-1){1'b0}}, 1'b1};
                        state_d = TRK_SKIP;
                    end
                end
            end
            TRK_SKIP: begin
                if (hs_q_i) begin
                    state_d = TRK_SYNC;
                end else if (cnt_q == skip_i) begin
                    live_o  = 1'b1;
                    state_d = TRK_LIVE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TRK_LIVE: begin
                if (hs_q_i) begin
                    state_d = TRK_SYNC;
                end else begin
                    live_o = 1'b1;
                end
            end
            default: state_d = TRK_SYNC;
        endcase
    end

    // R8: the skip counter stays inside the programmed window
    a_r8_skip_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_SKIP) |-> (cnt_q != '0 && cnt_q <= skip_i));

endmodule

// File: rtl/pcap_assembler.sv
module pcap_assembler
    import pcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic             dual_i,
    input  logic             live_i,
    input  logic             restart_i,
    input  logic [BUS_W-1:0] slot0_i,
    input  logic [BUS_W-1:0] slot1_i,
    output logic             pix_vld_o,
    output logic [RED_W-1:0] red_o,
    output logic [GRN_W-1:0] grn_o,
    output logic [BLU_W-1:0] blu_o,
    output logic [BUS_W-1:0] luma_o,
    output logic [BUS_W-1:0] cb_o,
    output logic [BUS_W-1:0] cr_o
);

    asm_state_e       state_q;
    asm_state_e       state_d;
    logic [BUS_W-1:0] hold_q;
    logic [BUS_W-1:0] cb_q;
    logic [BUS_W-1:0] cr_q;
    logic             pend_q;

    logic             is_ycc;
    logic             emit_rgb;
    logic             emit_ycc;
    logic [RGB_W-1:0] rgb_w;
    logic [BUS_W-1:0] ycc_y;
    logic [BUS_W-1:0] ycc_cb;
    logic [BUS_W-1:0] ycc_cr;
    logic             ld_cb;
    logic             ld_cr;
    logic             ld_hold;
    logic [BUS_W-1:0] hold_d;
    logic             pend_d;

    assign is_ycc = (fmt_i == FMT_YCC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        emit_rgb = 1'b0;
        emit_ycc = pend_q;
        rgb_w    = '0;
        ycc_y    = hold_q;
        ycc_cb   = cb_q;
        ycc_cr   = cr_q;
        ld_cb    = 1'b0;
        ld_cr    = 1'b0;
        ld_hold  = 1'b0;
        hold_d   = slot0_i;
        pend_d   = 1'b0;
        if (restart_i) begin
            state_d = PH_A;
        end else if (live_i) begin
            unique case (state_q)
                PH_A: begin
                    if (is_ycc) begin
                        ld_cb = 1'b1;
                        if (dual_i) begin
                            ld_hold = 1'b1;
                            hold_d  = slot1_i;
                            state_d = PH_CR;
                        end else begin
                            state_d = PH_B;
                        end
                    end else if (dual_i) begin
                        emit_rgb = 1'b1;
                        rgb_w    = unpack_rgb(fmt_i, slot0_i, slot1_i);
                    end else begin
                        ld_hold = 1'b1;
                        state_d = PH_B;
                    end
                end
                PH_B: begin
                    if (is_ycc) begin
                        ld_hold = 1'b1;
                        state_d = PH_CR;
                    end else begin
                        emit_rgb = 1'b1;
                        rgb_w    = unpack_rgb(fmt_i, hold_q, slot0_i);
                        state_d  = PH_A;
                    end
                end
                PH_CR: begin
                    ld_cr    = 1'b1;
                    emit_ycc = 1'b1;
                    ycc_cr   = slot0_i;
                    if (dual_i) begin
                        ld_hold = 1'b1;
                        hold_d  = slot1_i;
                        pend_d  = 1'b1;
                        state_d = PH_A;
                    end else begin
                        state_d = PH_Y1;
                    end
                end
                PH_Y1: begin
                    emit_ycc = 1'b1;
                    ycc_y    = slot0_i;
                    state_d  = PH_A;
                end
                default: state_d = PH_A;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            cb_q      <= '0;
            cr_q      <= '0;
            pend_q    <= 1'b0;
            pix_vld_o <= 1'b0;
            red_o     <= '0;
            grn_o     <= '0;
            blu_o     <= '0;
            luma_o    <= '0;
            cb_o      <= '0;
            cr_o      <= '0;
        end else begin
            pend_q    <= pend_d;
            pix_vld_o <= emit_rgb | emit_ycc;
            if (ld_hold) hold_q <= hold_d;
            if (ld_cb)   cb_q   <= slot0_i;
            if (ld_cr)   cr_q   <= slot0_i;
            if (emit_rgb) begin
                {red_o, grn_o, blu_o} <= rgb_w;
            end
            if (emit_ycc) begin
                luma_o <= ycc_y;
                cb_o   <= ycc_cb;
                cr_o   <= ycc_cr;
            end
        end
    end

    // R5: single-edge RGB never yields two strobes back to back
    a_r5_rgb_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_o && !is_ycc && !dual_i) |=> !pix_vld_o);

    // R3: 5-5-5 output never sets the green MSB
    a_r3_green_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_o && fmt_i == FMT_555) |-> (grn_o[GRN_W-1] == 1'b0));

    // R4: a held second luma is always delivered on the next cycle
    a_r4_second_luma: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> pix_vld_o);

endmodule

// File: rtl/pcap_capture_top.sv
module pcap_capture_top
    import pcap_pkg::*;
#(
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        edge_sel_i,
    input  logic [1:0]        fmt_sel_i,
    input  logic [SKIP_W-1:0] skip_i,
    input  logic              hs_i,
    input  logic [7:0]        bus_i,
    output logic              pix_vld_o,
    output logic [4:0]        red_o,
    output logic [5:0]        grn_o,
    output logic [4:0]        blu_o,
    output logic [7:0]        luma_o,
    output logic [7:0]        cb_o,
    output logic [7:0]        cr_o
);

    logic             hs_q;
    logic             dual;
    logic [BUS_W-1:0] slot0;
    logic [BUS_W-1:0] slot1;
    logic             live;
    logic             restart;

    pcap_edge_front front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_sel_i (edge_sel_i),
        .hs_i       (hs_i),
        .bus_i      (bus_i),
        .hs_q_o     (hs_q),
        .dual_o     (dual),
        .slot0_o    (slot0),
        .slot1_o    (slot1)
    );

    pcap_line_tracker #(.SKIP_W(SKIP_W)) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_q_i    (hs_q),
        .skip_i    (skip_i),
        .live_o    (live),
        .restart_o (restart)
    );

    pcap_assembler assembler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt_sel_i),
        .dual_i    (dual),
        .live_i    (live),
        .restart_i (restart),
        .slot0_i   (slot0),
        .slot1_i   (slot1),
        .pix_vld_o (pix_vld_o),
        .red_o     (red_o),
        .grn_o     (grn_o),
        .blu_o     (blu_o),
        .luma_o    (luma_o),
        .cb_o      (cb_o),
        .cr_o      (cr_o)
    );

    // R7: two sampled sync cycles in a row leave the strobe low
    a_r7_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q && $past(hs_q)) |=> !pix_vld_o);

endmodule

// File: tb/pcap_capture_top_tb_top.sv
module pcap_capture_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] edge_sel_i = 2'b00;
    logic [1:0] fmt_sel_i = 2'b00;
    logic [7:0] skip_i = 8'd0;
    logic       hs_i = 1'b1;
    logic [7:0] bus_i = 8'h00;
    logic       pix_vld_o;
    logic [4:0] red_o;
    logic [5:0] grn_o;
    logic [4:0] blu_o;
    logic [7:0] luma_o;
    logic [7:0] cb_o;
    logic [7:0] cr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [23:0] exp_q[$];
    logic [23:0] got_q[$];

    localparam logic [7:0] FILL = 8'hEE;

    always #10 clk = ~clk;

    pcap_capture_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_sel_i (edge_sel_i),
        .fmt_sel_i  (fmt_sel_i),
        .skip_i     (skip_i),
        .hs_i       (hs_i),
        .bus_i      (bus_i),
        .pix_vld_o  (pix_vld_o),
        .red_o      (red_o),
        .grn_o      (grn_o),
        .blu_o      (blu_o),
        .luma_o     (luma_o),
        .cb_o       (cb_o),
        .cr_o       (cr_o)
    );

    always @(negedge clk) begin
        if (rst_n && pix_vld_o) begin
            if (fmt_sel_i == 2'b10) got_q.push_back({luma_o, cb_o, cr_o});
            else got_q.push_back({3'b0, red_o, 2'b0, grn_o, 3'b0, blu_o});
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // a: byte before the rising edge, b: byte before the falling edge
    task automatic cyc(input logic hs, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); #5;
        hs_i  = hs;
        bus_i = a;
        @(posedge clk); #5;
        bus_i = b;
    endtask

    task automatic put(input logic [1:0] em, input logic [7:0] v);
        if (em == 2'b00) cyc(1'b0, v, FILL);
        else cyc(1'b0, FILL, v);
    endtask

    task automatic run_line(input logic [1:0] em, input logic [1:0] fm, input logic [7:0] sk,
                            input int seed, input bit stray);
        string tag;
        edge_sel_i = em;
        fmt_sel_i  = fm;
        skip_i     = sk;
        got_q.delete();
        exp_q.delete();
        if (stray) cyc(1'b0, 8'h5A, 8'h5A);
        for (int i = 0; i < 3; i++) cyc(1'b1, FILL, FILL);
        for (int i = 0; i < sk; i++) cyc(1'b0, FILL, FILL);
        if (fm == 2'b10) begin
            for (int j = 0; j < 3; j++) begin
                logic [7:0] cb, y0, cr, y1;
                cb = 8'h10 + 8'(j * 17 + seed);
                y0 = 8'(j * 29 + seed + 3);
                cr = 8'hF0 - 8'(j * 7 + seed);
                y1 = y0 + 8'h55;
                exp_q.push_back({y0, cb, cr});
                exp_q.push_back({y1, cb, cr});
                if (em[1]) begin
                    cyc(1'b0, cb, y0);
                    cyc(1'b0, cr, y1);
                end else begin
                    put(em, cb); put(em, y0); put(em, cr); put(em, y1);
                end
            end
        end else begin
            for (int k = 0; k < 6; k++) begin
                logic [4:0] r, bl;
                logic [5:0] g;
                logic [7:0] pa, pb;
                r  = 5'(k * 5 + seed);
                g  = 6'(k * 13 + seed * 3);
                bl = 5'(k * 11 + seed + 7);
                if (fm == 2'b01) begin
                    g[5] = 1'b0;
                    pb = {k[0], r, g[4:3]};
                end else begin
                    pb = {r, g[5:3]};
                end
                pa = {g[2:0], bl};
                exp_q.push_back({3'b0, r, 2'b0, g, 3'b0, bl});
                if (em[1]) cyc(1'b0, pa, pb);
                else begin
                    put(em, pa); put(em, pb);
                end
            end
        end
        for (int i = 0; i < 3; i++) cyc(1'b1, FILL, FILL);
        tag = (fm == 2'b00) ? "R2" : (fm == 2'b01) ? "R3" : "R4";
        check(got_q.size() == exp_q.size(),
              $sformatf("R5 R4 R8 R7 count edge=%0d fmt=%0d skip=%0d", em, fm, sk),
              got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            logic [23:0] gv;
            gv = (i < got_q.size()) ? got_q[i] : 24'hXXXXXX;
            check(gv === exp_q[i],
                  $sformatf("%s R6 item %0d edge=%0d fmt=%0d skip=%0d", tag, i, em, fm, sk),
                  gv, exp_q[i]);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #3 rst_n = 1'b1;
                repeat (2) @(negedge clk);
                check(pix_vld_o == 1'b0, "R1 strobe after reset", pix_vld_o, 0);
                repeat (4) cyc(1'b1, FILL, FILL);
                check(pix_vld_o == 1'b0 && got_q.size() == 0, "R1 quiet before data",
                      got_q.size(), 0);
                for (int e = 0; e < 3; e++) begin
                    for (int f = 0; f < 3; f++) begin
                        for (int s = 0; s < 3; s++) begin
                            int sk;
                            sk = (s == 2) ? 3 : s;
                            run_line(2'(e), 2'(f), 8'(sk), e * 9 + f * 3 + s, 1'b0);
                        end
                    end
                end
                // R7: a lone phase a before sync must vanish
                run_line(2'b00, 2'b00, 8'd0, 40, 1'b1);
                run_line(2'b10, 2'b01, 8'd2, 41, 1'b1);
                run_line(2'b11, 2'b10, 8'd1, 42, 1'b0);
                done = 1'b1;
            end
            begin
                repeat (50000) @(posedge clk);
                if (!done) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL watchdog expired actual=hung expected=finish");
                end
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule